// File: doc/BRIEF.md
# Folded Four-Step Complex Multiplier

The block forms the product of two complex numbers, (a + jb)·(c + jd), with a single signed multiplier and one 48-bit accumulator. Each input pair occupies four clock cycles. A 2-bit phase counter indexes a four-entry table of 7-bit step words. On every cycle the current step word sets up the datapath: it picks the multiplier operands and chooses whether the product starts a fresh sum or is added to the running one. It also says whether the product is negated, and whether the sum is captured as the real or the imaginary result.

Operands are taken only on a phase-0 edge. They then stay in holding registers for the rest of the group, so the input rate is at most one pair every four clocks. The order of steps is fixed:
- phase 1: −b·d, started fresh
- phase 2: +a·c, accumulated, and the sum is captured as the real part
- phase 3: a·d, started fresh
- next phase 0: +b·c, accumulated, and the sum is captured as the imaginary part

A single enable input freezes or runs the counter, and with it the whole sequence.

Top module: `cmx_fold_mul`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, out_valid is 0 and the phase counter is at 0.
- R2: The phase counter advances by one, modulo 4, on each rising edge with en=1, and holds on edges with en=0. A paused group resumes where it stopped.
- R3: A pair is accepted only on an edge where en=1, the phase is 0 and in_valid=1. in_valid on any other edge is ignored and produces no output.
- R4: out_re equals a·c − b·d, sign-extended to 48 bits, with no rounding.
- R5: out_im equals a·d + b·c, sign-extended to 48 bits, with no rounding.
- R6: out_valid is high for exactly one cycle. It rises after the fourth enabled edge that follows the accepting edge, and this is the same edge that is the next phase-0 edge.
- R7: Once accepted, the operands are held. Changes on in_a..in_d during the group do not alter its result.
- R8: The extreme operand −131072 in every position gives out_re = 0 and out_im = 2^35, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global enable; runs the phase counter and datapath |
| in_valid | input | 1 | Qualifies the operands on a phase-0 edge |
| in_a | input | 18 | Real part of the first factor, signed |
| in_b | input | 18 | Imaginary part of the first factor, signed |
| in_c | input | 18 | Real part of the second factor, signed |
| in_d | input | 18 | Imaginary part of the second factor, signed |
| out_valid | output | 1 | One-cycle strobe; both results are valid |
| out_re | output | 48 | Real result, signed |
| out_im | output | 48 | Imaginary result, signed |

## Verification
A wrong phase count or a wrong step-word entry shows at the ports within one group, four enabled clocks. In that case out_valid lands on the wrong edge, or one of the two results is off by a whole partial product or has its sign flipped. A holding register that reloads in the middle of a group corrupts the next strobe's values. Because inputs change on every cycle, that error shows up within four enabled clocks. A counter that ignores en shifts every later strobe, and the first random gap in en exposes it.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

  typedef struct packed {
    logic ld;      // load holding registers on this step
    logic x_is_b;  // left operand: 0 = a, 1 = b
    logic y_is_d;  // right operand: 0 = c, 1 = d
    logic neg;     // subtract the product
    logic fresh;   // start from zero instead of the running sum
    logic cap_re;  // capture sum as real result
    logic cap_im;  // capture sum as imaginary result
  } step_t;

  function automatic step_t step_for(input logic [1:0] ph);
    step_t s;
    s = '0;
    unique case (ph)
      2'd1: begin s.x_is_b = 1'b1; s.y_is_d = 1'b1; s.neg = 1'b1; s.fresh = 1'b1; end
      2'd2: begin s.cap_re = 1'b1; end
      2'd3: begin s.y_is_d = 1'b1; s.fresh = 1'b1; end
      default: begin s.ld = 1'b1; s.x_is_b = 1'b1; s.cap_im = 1'b1; end
    endcase
    return s;
  endfunction

  function automatic logic signed [47:0] mac_next(
    input logic signed [47:0] acc,
    input logic signed [35:0] prod,
    input logic               neg,
    input logic               fresh);
    logic signed [47:0] term;
    term = neg ? -48'(prod) : 48'(prod);
    return fresh ? term : acc + term;
  endfunction

endpackage

// File: rtl/cmx_seq.sv
module cmx_seq
  import cmx_pkg::*;
#(
  parameter int STEPS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  output step_t step,
  output logic  phase_zero
);
  localparam int PW = $clog2(STEPS);

  logic [PW-1:0] ph;
  step_t         tbl [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_tbl
    assign tbl[i] = step_for(2'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ph <= '0;
    else if (en) ph <= ph + 1'b1;
  end

  assign step       = tbl[ph];
  assign phase_zero = (ph == '0);

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ph == PW'($past(ph) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ph));
  a_r6_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !(step.cap_re && step.cap_im));

endmodule

// File: rtl/cmx_mac.sv
module cmx_mac
  import cmx_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  step_t                step,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  input  logic signed [DW-1:0] in_c,
  input  logic signed [DW-1:0] in_d,
  output logic                 load_fire,
  output logic                 cap_im_fire,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_re,
  output logic signed [AW-1:0] out_im
);
  localparam int PWID = 2 * DW;

  logic signed [DW-1:0]   ha, hb, hc, hd;
  logic                   grp_vld;
  logic signed [DW-1:0]   opx, opy;
  logic signed [PWID-1:0] prod;
  logic signed [AW-1:0]   acc, acc_nx;

  assign load_fire   = en && step.ld;
  assign cap_im_fire = en && step.cap_im;

  assign opx    = step.x_is_b ? hb : ha;
  assign opy    = step.y_is_d ? hd : hc;
  assign prod   = opx * opy;
  assign acc_nx = mac_next(acc, 36'(prod), step.neg, step.fresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ha <= '0; hb <= '0; hc <= '0; hd <= '0;
      grp_vld <= 1'b0;
    end else if (load_fire) begin
      ha <= in_a; hb <= in_b; hc <= in_c; hd <= in_d;
      grp_vld <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0; out_re <= '0; out_im <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= cap_im_fire && grp_vld;
      if (en) begin
        acc <= acc_nx;
        if (step.cap_re) out_re <= acc_nx;
        if (step.cap_im) out_im <= acc_nx;
      end
    end
  end

  a_r7_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> $stable({ha, hb, hc, hd, grp_vld}));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r4_re_stable_while_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $stable(out_re));

endmodule

// File: rtl/cmx_fold_mul.sv
module cmx_fold_mul
  import cmx_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_a,
  input  logic signed [DW-1:0] in_b,
  input  logic signed [DW-1:0] in_c,
  input  logic signed [DW-1:0] in_d,
  output logic                 out_valid,
  output logic signed [AW-1:0] out_re,
  output logic signed [AW-1:0] out_im
);
  step_t step;
  logic  phase_zero, load_fire, cap_im_fire;

  cmx_seq #(.STEPS(4)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step), .phase_zero(phase_zero)
  );

  cmx_mac #(.DW(DW), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .load_fire(load_fire), .cap_im_fire(cap_im_fire),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  a_r3_load_on_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |-> phase_zero && en);
  a_r6_valid_after_load_edge: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(load_fire) && $past(cap_im_fire));
  a_r1_idle_without_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid);

endmodule

// File: tb/tb_cmx_fold_mul.sv
module tb_cmx_fold_mul;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, in_valid = 1'b0;
  logic signed [17:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic out_valid;
  logic signed [47:0] out_re, out_im;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  int ph = 0;
  bit pend = 0, expv = 0;
  logic signed [17:0] pa, pb, pc, pd;
  logic signed [47:0] exp_re, exp_im;

  always #10 clk = ~clk;

  cmx_fold_mul dut (.*);

  function automatic logic signed [47:0] ref_re(input logic signed [17:0] a, b, c, d);
    longint p1, p2;
    p1 = longint'(a) * longint'(c);
    p2 = longint'(b) * longint'(d);
    return 48'(p1 - p2);
  endfunction

  function automatic logic signed [47:0] ref_im(input logic signed [17:0] a, b, c, d);
    longint s;
    s = longint'(a + 19'sd0) * longint'(d) + longint'(c) * longint'(b);
    return 48'(s);
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit e, input bit v,
                      input logic signed [17:0] a, b, c, d);
    @(negedge clk);
    check(out_valid == expv, "R6 out_valid", longint'(out_valid), longint'(expv));
    if (expv) begin
      check(out_re == exp_re, "R4 out_re", out_re, exp_re);
      check(out_im == exp_im, "R5 out_im", out_im, exp_im);
    end
    en = e; in_valid = v; in_a = a; in_b = b; in_c = c; in_d = d;
    expv = 0;
    if (e) begin
      if (ph == 0) begin
        expv = pend;
        exp_re = ref_re(pa, pb, pc, pd);
        exp_im = ref_im(pa, pb, pc, pd);
        pend = v; pa = a; pb = b; pc = c; pd = d;
      end
      ph = (ph + 1) % 4;
    end
  endtask

  function automatic logic signed [17:0] r18();
    return 18'($urandom);
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);

    // directed: basic product, continuous enable
    tag = "R4 R5";
    step(1, 1, 18'sd3, 18'sd4, 18'sd5, -18'sd6);
    repeat (3) step(1, 0, r18(), r18(), r18(), r18());
    step(1, 0, 0, 0, 0, 0);
    // R8: extreme negatives
    tag = "R8";
    step(1, 0, 0, 0, 0, 0); repeat (2) step(1, 0, 0, 0, 0, 0);
    step(1, 1, -18'sd131072, -18'sd131072, -18'sd131072, -18'sd131072);
    repeat (3) step(1, 0, 18'sd131071, 18'sd131071, 18'sd131071, 18'sd131071);
    step(1, 1, 18'sd131071, -18'sd131072, -18'sd131072, 18'sd131071);
    repeat (3) step(1, 0, r18(), r18(), r18(), r18());
    step(1, 0, 0, 0, 0, 0);

    // R3: in_valid only off phase 0 -> no output
    tag = "R3";
    for (int k = 0; k < 16; k++)
      step(1, (k % 4) != 3, r18(), r18(), r18(), r18());

    // R7: back-to-back groups with inputs changing every cycle
    tag = "R7";
    for (int k = 0; k < 40; k++)
      step(1, 1, r18(), r18(), r18(), r18());

    // R2: random enable gaps pause the sequence
    tag = "R2";
    for (int k = 0; k < 3000; k++)
      step(($urandom % 100) < 80, ($urandom % 100) < 70, r18(), r18(), r18(), r18());

    // R6: drain with enable held low, then finish the last group
    tag = "R6";
    repeat (6) step(0, 1, r18(), r18(), r18(), r18());
    repeat (8) step(1, 0, r18(), r18(), r18(), r18());

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule